// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps the contents of an SDRAM alive while an access arbiter runs normal traffic. A down-counter, loaded from a parameter that gives the refresh period in clock cycles, adds one unit to a refresh debt each time it expires. While any debt is owed, the block raises a request to the arbiter. When the arbiter grants, it has closed every bank. The manager then takes the command bus, issues one AUTO REFRESH, and drives only NOPs for the tRC window before it hands the bus back. Once the debt reaches a set level, the request is flagged urgent, so the arbiter stops taking new accesses, precharges all banks and grants.

A sleep request uses the same grant path. Once granted, the manager drives the refresh command with the clock-enable pin low, which puts the device into self refresh. Clock enable stays low for at least tRAS and for as long as sleep is requested. On wake, clock enable goes high and NOPs are driven for the longer of tRC and two cycles. Because the row the device refreshed last cannot be known, the manager then runs a full sweep of back-to-back refreshes, each spaced by tRC, before it releases the bus.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: After reset, clock enable is high, chip select is high (inhibit), and neither the request nor the bus-ownership output is set.
- R2: Each time REFI_CYC cycles pass without a refresh being issued, one unit of debt is added. The interval timer restarts whenever a refresh is issued. The request is high in the idle state whenever the debt is non-zero or sleep is requested.
- R3: The debt saturates at DEBT_SAT (8). After a long stall, exactly 8 granted refreshes clear the request.
- R4: The urgent output is high exactly when the request is high and the debt is at least URGENT_DEBT.
- R5: A grant seen while the request is high makes the next cycle a refresh command (chip select, RAS and CAS low, WE high) with bus ownership high. A grant seen while the request is low has no effect.
- R6: After each refresh command, only NOPs (chip select low, RAS, CAS and WE high) are driven for TRC_CYC-1 cycles. No other command appears sooner than TRC_CYC cycles after a refresh.
- R7: A grant given while sleep is requested produces a refresh command with clock enable low. Clock enable then stays low for at least TRAS_CYC cycles, and for as long as sleep stays requested.
- R8: When clock enable returns high, NOPs are driven for max(TRC_CYC,2) cycles before the next command.
- R9: After that wait, exactly SWEEP_CNT refreshes are issued, each spaced by TRC_CYC, with no new grant. The bus is then released with zero debt.
- R10: The request is never high while the manager owns the bus. While the bus is not owned, chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Arbiter grant: all banks precharged, bus yielded |
| sleep_req | input | 1 | Level: high asks for self refresh, low asks for wake |
| ref_req | output | 1 | Refresh or sleep request to the arbiter |
| ref_urgent | output | 1 | Request has been postponed too long |
| bus_own | output | 1 | Manager drives the SDRAM command pins |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |

## Verification
The bench builds the block with a 40-cycle refresh interval, tRC of 4, tRAS of 6, a sweep of 3 refreshes and an urgent level of 2. These values let debt build up, reach the urgent level and hit the saturation cap of 8 within a few hundred cycles. They also keep the post-wake sweep short enough to count every refresh in it. Two sleep episodes are run. A long one checks that clock enable stays low while sleep is held. A short one checks that clock enable stays low for exactly the minimum tRAS.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_TRC,
        ST_SRE,
        ST_SLEEP,
        ST_XNOP
    } mgr_state_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdram_pins_t;

    localparam sdram_pins_t PINS_INHIBIT = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_pins_t PINS_NOP     = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_pins_t PINS_REFRESH = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdram_pins_t PINS_SR_IN   = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdram_pins_t PINS_ASLEEP  = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/srm_debt_tracker.sv
module srm_debt_tracker #(
    parameter int REFI_CYC = 3906,
    parameter int DEBT_SAT = 8,
    parameter int DW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          issued_i,
    output logic [DW-1:0] debt_o
);
    localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(REFI_CYC - 1);
    localparam logic [DW-1:0] CAP    = DW'(DEBT_SAT);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [DW-1:0] debt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear_i) begin
            // device refreshes itself; the sweep that follows settles the debt
            trk_d.tmr  = RELOAD;
            trk_d.debt = '0;
        end else if (issued_i) begin
            trk_d.tmr = RELOAD;
            if (trk_q.debt != '0) trk_d.debt = trk_q.debt - 1'b1;
        end else if (trk_q.tmr == '0) begin
            trk_d.tmr = RELOAD;
            if (trk_q.debt != CAP) trk_d.debt = trk_q.debt + 1'b1;
        end else begin
            trk_d.tmr = trk_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '{tmr: RELOAD, debt: '0};
        else        trk_q <= trk_d;
    end

    assign debt_o = trk_q.debt;
endmodule

// File: rtl/srm_pin_decode.sv
module srm_pin_decode
    import sdram_ref_pkg::*;
(
    input  mgr_state_e  state_i,
    output sdram_pins_t pins_o
);
    always_comb begin
        unique case (state_i)
            ST_IDLE:         pins_o = PINS_INHIBIT;
            ST_REF:          pins_o = PINS_REFRESH;
            ST_TRC, ST_XNOP: pins_o = PINS_NOP;
            ST_SRE:          pins_o = PINS_SR_IN;
            ST_SLEEP:        pins_o = PINS_ASLEEP;
            default:         pins_o = PINS_INHIBIT;
        endcase
    end
endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
    import sdram_ref_pkg::*;
#(
    parameter int REFI_CYC    = 3906,
    parameter int TRC_CYC     = 16,
    parameter int TRAS_CYC    = 11,
    parameter int SWEEP_CNT   = 4096,
    parameter int URGENT_DEBT = 4,
    parameter int DEBT_SAT    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    input  logic sleep_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic bus_own,
    output logic sd_cke,
    output logic sd_cs_n,
    output logic sd_ras_n,
    output logic sd_cas_n,
    output logic sd_we_n
);
    localparam int EXIT_CYC = (TRC_CYC > 2) ? TRC_CYC : 2;
    localparam int MAX_A    = (TRC_CYC > TRAS_CYC) ? TRC_CYC : TRAS_CYC;
    localparam int WAIT_MAX = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
    localparam int CW       = $clog2(WAIT_MAX + 1);
    localparam int SW       = $clog2(SWEEP_CNT + 1);
    localparam int DW       = $clog2(DEBT_SAT + 1);

    typedef struct packed {
        mgr_state_e    state;
        logic [CW-1:0] cnt;
        logic [SW-1:0] sweep;
    } fsm_t;

    fsm_t        fsm_d, fsm_q;
    logic [DW-1:0] debt_w;
    logic        req_w;
    logic        clear_w;
    logic        issued_w;
    sdram_pins_t pins_w;

    assign clear_w  = (fsm_q.state == ST_SRE) || (fsm_q.state == ST_SLEEP) || (fsm_q.state == ST_XNOP);
    assign issued_w = (fsm_q.state == ST_REF);

    srm_debt_tracker #(
        .REFI_CYC(REFI_CYC),
        .DEBT_SAT(DEBT_SAT),
        .DW      (DW)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_w),
        .issued_i(issued_w),
        .debt_o  (debt_w)
    );

    assign req_w = (fsm_q.state == ST_IDLE) && ((debt_w != '0) || sleep_req);

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (req_w && ref_grant) fsm_d.state = sleep_req ? ST_SRE : ST_REF;
            end
            ST_REF: begin
                fsm_d.state = ST_TRC;
                fsm_d.cnt   = CW'(TRC_CYC - 2);
            end
            ST_TRC: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end else if (fsm_q.sweep != '0) begin
                    fsm_d.state = ST_REF;
                    fsm_d.sweep = fsm_q.sweep - 1'b1;
                end else begin
                    fsm_d.state = ST_IDLE;
                end
            end
            ST_SRE: begin
                fsm_d.state = ST_SLEEP;
                fsm_d.cnt   = CW'(TRAS_CYC - 2);
            end
            ST_SLEEP: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end else if (!sleep_req) begin
                    fsm_d.state = ST_XNOP;
                    fsm_d.cnt   = CW'(EXIT_CYC - 1);
                end
            end
            ST_XNOP: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end else begin
                    fsm_d.state = ST_REF;
                    fsm_d.sweep = SW'(SWEEP_CNT - 1);
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{state: ST_IDLE, cnt: '0, sweep: '0};
        else        fsm_q <= fsm_d;
    end

    srm_pin_decode u_pins (
        .state_i(fsm_q.state),
        .pins_o (pins_w)
    );

    assign ref_req    = req_w;
    assign ref_urgent = req_w && (debt_w >= DW'(URGENT_DEBT));
    assign bus_own    = (fsm_q.state != ST_IDLE);
    assign sd_cke     = pins_w.cke;
    assign sd_cs_n    = pins_w.cs_n;
    assign sd_ras_n   = pins_w.ras_n;
    assign sd_cas_n   = pins_w.cas_n;
    assign sd_we_n    = pins_w.we_n;
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int TRC_CYC  = 16,
    parameter int TRAS_CYC = 11,
    parameter int DEBT_SAT = 8,
    parameter int DW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke,
    input logic          cs_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          ref_req,
    input logic          ref_urgent,
    input logic          bus_own,
    input logic [DW-1:0] debt
);
    logic is_ref, is_nop;
    int   since_q;
    int   low_q;

    assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
    assign is_nop = !cs_n && ras_n && cas_n && we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= TRC_CYC;
            low_q   <= 0;
        end else begin
            since_q <= is_ref ? 1 : ((since_q < TRC_CYC) ? since_q + 1 : since_q);
            low_q   <= cke ? 0 : ((low_q < TRAS_CYC) ? low_q + 1 : low_q);
        end
    end

    // R10
    req_excl_own_chk: assert property (@(posedge clk) disable iff (!rst_n) ref_req |-> !bus_own);
    // R10
    idle_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_own |-> (cs_n && cke));
    // R4
    urgent_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) ref_urgent |-> ref_req);
    // R3
    debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) debt <= DW'(DEBT_SAT));
    // R6
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && !is_nop) |-> (since_q >= TRC_CYC));
    // R7
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cke) |-> is_ref);
    // R7
    sr_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> (low_q >= TRAS_CYC));
    // R8
    exit_nop_now_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> is_nop);
    // R8
    exit_nop_next_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |=> is_nop);
endmodule

bind sdram_refresh_mgr srm_checker #(
    .TRC_CYC (TRC_CYC),
    .TRAS_CYC(TRAS_CYC),
    .DEBT_SAT(DEBT_SAT),
    .DW      (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (sd_cke),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .bus_own   (bus_own),
    .debt      (debt_w)
);

// File: tb/tb_sdram_refresh_mgr.sv
`timescale 1ns/1ps
module tb_sdram_refresh_mgr;
    localparam int REFI  = 40;
    localparam int TRC   = 4;
    localparam int TRAS  = 6;
    localparam int SWEEP = 3;
    localparam int URG   = 2;
    localparam int SAT   = 8;
    localparam int EXIT  = (TRC > 2) ? TRC : 2;

    logic clk = 0, rst_n = 0, ref_grant = 0, sleep_req = 0;
    logic ref_req, ref_urgent, bus_own, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;

    sdram_refresh_mgr #(
        .REFI_CYC(REFI), .TRC_CYC(TRC), .TRAS_CYC(TRAS),
        .SWEEP_CNT(SWEEP), .URGENT_DEBT(URG), .DEBT_SAT(SAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .sleep_req(sleep_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_own(bus_own),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
    );

    always #2 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: 0 idle, 1 refresh, 2 tRC wait, 3 sleep entry, 4 asleep, 5 exit NOPs
    int m_mode = 0, m_left = 0, m_sweep = 0, m_tmr = REFI - 1, m_debt = 0;
    bit m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_sweep = 0; m_tmr = REFI - 1; m_debt = 0;
        end else begin
            m_req = (m_mode == 0) && (m_debt > 0 || sleep_req);
            if (m_mode >= 3) begin
                m_tmr = REFI - 1; m_debt = 0;
            end else if (m_mode == 1) begin
                m_tmr = REFI - 1;
                if (m_debt > 0) m_debt--;
            end else if (m_tmr == 0) begin
                m_tmr = REFI - 1;
                if (m_debt < SAT) m_debt++;
            end else begin
                m_tmr--;
            end
            case (m_mode)
                0: if (m_req && ref_grant) m_mode = sleep_req ? 3 : 1;
                1: begin m_mode = 2; m_left = TRC - 1; end
                2: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_sweep > 0) begin m_sweep--; m_mode = 1; end
                        else m_mode = 0;
                    end
                end
                3: begin m_mode = 4; m_left = TRAS - 1; end
                4: if (m_left > 1) m_left--;
                   else if (!sleep_req) begin m_mode = 5; m_left = EXIT; end
                5: begin
                    m_left--;
                    if (m_left == 0) begin m_mode = 1; m_sweep = SWEEP - 1; end
                end
                default: m_mode = 0;
            endcase
        end
    end

    // port monitor counters
    int ref_cnt = 0, low_run = 0, last_low = 0, exit_nops = 0, last_exit = 0;
    bit prev_cke = 1, in_exit = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && sd_cke;
            automatic bit is_nop = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
            automatic int e_cke  = (m_mode == 3 || m_mode == 4) ? 0 : 1;
            automatic int e_cmd;
            automatic int e_req  = (m_mode == 0) && (m_debt > 0 || sleep_req);
            case (m_mode)
                1, 3:    e_cmd = 4'b0001;
                2, 5:    e_cmd = 4'b0111;
                default: e_cmd = 4'b1111;
            endcase
            chk("R8 cke", sd_cke, e_cke);
            chk("R6 cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
            chk("R2 req", ref_req, e_req);
            chk("R4 urgent", ref_urgent, e_req && (m_debt >= URG));
            chk("R10 own", bus_own, m_mode != 0);
            if (is_ref) ref_cnt++;
            if (!sd_cke) low_run++;
            if (sd_cke && !prev_cke) begin
                last_low = low_run; low_run = 0; in_exit = 1; exit_nops = 0;
            end
            if (in_exit) begin
                if (is_nop) exit_nops++;
                else if (is_ref) begin last_exit = exit_nops; in_exit = 0; end
            end
            prev_cke = sd_cke;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cke", sd_cke, 1);
        chk("R1 cs_n", sd_cs_n, 1);
        chk("R1 req", ref_req, 0);
        chk("R1 own", bus_own, 0);
        #1 rst_n = 1;

        step(50);
        chk("R2 request after interval", ref_req, 1);
        ref_cnt = 0;
        ref_grant = 1;
        step(10);
        chk("R5 single refresh, held grant ignored", ref_cnt, 1);
        chk("R5 request cleared", ref_req, 0);
        ref_grant = 0;

        step(90);
        chk("R4 urgent at two owed", ref_urgent, 1);

        step(400);
        ref_cnt = 0;
        ref_grant = 1;
        step(60);
        chk("R3 saturated debt drained", ref_cnt, SAT);
        chk("R3 request cleared", ref_req, 0);
        ref_grant = 0;

        sleep_req = 1; ref_grant = 1;
        step(2);
        ref_grant = 0;
        step(20);
        chk("R7 held low while sleeping", sd_cke, 0);
        sleep_req = 0;
        ref_cnt = 0;
        step(40);
        chk("R7 long sleep length", last_low >= 20 ? 1 : 0, 1);
        chk("R8 exit NOP count", last_exit, EXIT);
        chk("R9 sweep refresh count", ref_cnt, SWEEP);
        chk("R9 bus released", bus_own, 0);

        sleep_req = 1; ref_grant = 1;
        step(1);
        sleep_req = 0; ref_grant = 0;
        ref_cnt = 0;
        step(40);
        chk("R7 minimum sleep length", last_low, TRAS);
        chk("R8 exit NOP count short", last_exit, EXIT);
        chk("R9 sweep count short", ref_cnt, SWEEP);
        chk("R9 request idle", ref_req, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule